// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves a device data buffer to or from a list of memory regions. Software builds a table of 8-byte region descriptors in memory, loads the table base into the engine and pulses start together with the number of bytes the device needs and the transfer direction. The engine fetches descriptors one at a time over a simple request/acknowledge read port. For each region it issues burst requests on a second request/acknowledge port until the device's byte count is used up.

Each descriptor holds a 32-bit region address in its low word and a size/flags word in its high word. The region length is taken from the low 16 bits of the size word with bit 0 cleared, and zero encodes a full 64 KiB region. Bit 31 of the size word marks the final descriptor. The walk ends in one of three ways, each reported by a one-cycle pulse. The device count can reach zero (done). The table can end while bytes are still owed (end-of-table). The descriptor pointer can reach a fixed fail-safe distance past the base while bytes are still owed (overrun).

Top module: `sgd_dma_engine`

## Requirements
- R1: After reset the engine is idle with no request raised and no status pulse, and the table base reads as zero, so a start issued without loading a base fetches its first descriptor from address 0.
- R2: Descriptors are fetched from the table base upward in steps of 8 bytes. In the returned 64-bit word, bits 31:0 are the region address and bits 63:32 are the size/flags word.
- R3: The region byte count is bits 15:0 of the size word with bit 0 forced to zero, so an odd size field yields the next lower even count.
- R4: A masked count of zero describes a region of 0x10000 bytes.
- R5: Bit 31 of the size word marks the last descriptor. When that region is exhausted and the device still needs bytes, no further descriptor is fetched and a one-cycle end-of-table pulse is raised instead of done.
- R6: No descriptor is fetched once the pointer is TBL_LIMIT (4096) bytes or more past the base. If bytes are still owed at that point, a one-cycle overrun pulse is raised.
- R7: Each burst moves the smaller of the bytes the device still needs and the bytes left in the current region. The region address advances by that amount. A new descriptor is fetched only when the region's remaining count is zero.
- R8: A start clears the current region state (address, remaining count, last flag) and restarts the descriptor pointer at the base, so leftover bytes of a previous region are never reused.
- R9: No burst crosses a BURST_PAGE (4096-byte) address boundary. A chunk that would cross one is issued as two bursts split at the boundary.
- R10: The burst write flag equals the direction input sampled at start (1: device to memory).
- R11: A one-cycle done pulse is raised when the device count reaches zero, including a start with a count of zero, which completes without any fetch. At most one of done, end-of-table and overrun is raised in a cycle, and the engine is idle when it is raised.
- R12: At most one request (descriptor or burst) is outstanding at a time, and a raised request holds its address, length and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_we_i | input | 1 | Load the table base register |
| base_i | input | ADDR_W | Table base value to load |
| start_i | input | 1 | Start pulse, accepted when idle |
| dir_i | input | 1 | Direction: 1 device to memory, 0 memory to device |
| len_i | input | LEN_W | Bytes the device needs, sampled at start |
| dsc_req_o | output | 1 | Descriptor read request |
| dsc_addr_o | output | ADDR_W | Descriptor read address |
| dsc_ack_i | input | 1 | Descriptor read acknowledge, data valid |
| dsc_data_i | input | 64 | Descriptor word (little-endian pair of 32-bit words) |
| bst_req_o | output | 1 | Burst request |
| bst_wr_o | output | 1 | Burst is a memory write |
| bst_addr_o | output | ADDR_W | Burst start address |
| bst_len_o | output | 17 | Burst byte count |
| bst_ack_i | input | 1 | Burst acknowledge |
| busy_o | output | 1 | Engine is walking a table |
| done_o | output | 1 | Device count satisfied (pulse) |
| eot_o | output | 1 | Table ended with bytes still owed (pulse) |
| ovr_o | output | 1 | Fail-safe pointer limit reached with bytes still owed (pulse) |

## Verification
The bench goes after the length encoding. An odd size field would give an odd burst if bit 0 were not masked, and a zero field would give a zero-length or stuck burst if the 64 KiB rule were missing. It places a region just below a 4 KiB boundary: an engine that did not split would issue one crossing burst where two are expected. It restarts with a table whose first region was only partly used; an engine that kept the old region state would continue at the stale address instead of refetching from the base. The three endings are driven separately, since a mix-up there would show as the wrong pulse, a missing pulse or a fetch beyond the last flag or the 4096-byte window. These cases are a last flag reached early, 512 small unflagged descriptors, and a count that ends mid-region.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int unsigned SGD_DESC_W    = 64;
   localparam int unsigned SGD_RGN_W     = 17;
   localparam int unsigned SGD_DESC_STEP = 8;
   localparam logic [15:0] SGD_CNT_MASK  = 16'hFFFE;

   typedef enum logic [1:0] {
      SGD_IDLE,
      SGD_EVAL,
      SGD_FETCH,
      SGD_MOVE
   } sgd_state_e;

   typedef struct packed {
      logic                 last;
      logic [SGD_RGN_W-1:0] len;
   } sgd_size_t;
endpackage

// File: rtl/sgd_desc_decode.sv
module sgd_desc_decode
   import sgd_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [SGD_DESC_W-1:0] desc_i,
   output logic [ADDR_W-1:0]     addr_o,
   output sgd_size_t             size_o
);
   logic [31:0] word_addr;
   logic [31:0] word_size;
   logic [15:0] cnt;

   assign word_addr = desc_i[31:0];
   assign word_size = desc_i[63:32];
   assign cnt       = word_size[15:0] & SGD_CNT_MASK;
   assign addr_o    = word_addr[ADDR_W-1:0];

   always_comb begin
      size_o.last = word_size[31];
      size_o.len  = (cnt == 16'd0) ? SGD_RGN_W'(17'h10000) : {1'b0, cnt};
   end

   logic unused_flags;
   assign unused_flags = ^{word_size[30:16], word_size[0]};

   generate
      if (ADDR_W < 32) begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^word_addr[31:ADDR_W];
      end
   endgenerate
endmodule

// File: rtl/sgd_chunk_sel.sv
module sgd_chunk_sel
   import sgd_pkg::*;
#(
   parameter int unsigned LEN_W      = 24,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BURST_PAGE = 4096,
   parameter bit          SPLIT_EN   = 1'b1
) (
   input  logic [LEN_W-1:0]     need_i,
   input  logic [SGD_RGN_W-1:0] rem_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [SGD_RGN_W-1:0] chunk_o
);
   localparam int unsigned BP_W = $clog2(BURST_PAGE);

   logic [SGD_RGN_W-1:0] need_cap;

   assign need_cap = (need_i > LEN_W'(rem_i)) ? rem_i : need_i[SGD_RGN_W-1:0];

   generate
      if (SPLIT_EN) begin : g_split
         logic [SGD_RGN_W-1:0] room;
         assign room    = SGD_RGN_W'(BURST_PAGE) - SGD_RGN_W'(addr_i[BP_W-1:0]);
         assign chunk_o = (need_cap > room) ? room : need_cap;
         logic unused_addr;
         assign unused_addr = ^addr_i[ADDR_W-1:BP_W];
      end else begin : g_flat
         assign chunk_o = need_cap;
         logic unused_addr;
         assign unused_addr = ^addr_i;
      end
   endgenerate
endmodule

// File: rtl/sgd_dma_engine.sv
module sgd_dma_engine
   import sgd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 24,
   parameter int unsigned BURST_PAGE = 4096,
   parameter int unsigned TBL_LIMIT  = 4096,
   parameter bit          SPLIT_EN   = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  base_we_i,
   input  logic [ADDR_W-1:0]     base_i,
   input  logic                  start_i,
   input  logic                  dir_i,
   input  logic [LEN_W-1:0]      len_i,
   output logic                  dsc_req_o,
   output logic [ADDR_W-1:0]     dsc_addr_o,
   input  logic                  dsc_ack_i,
   input  logic [SGD_DESC_W-1:0] dsc_data_i,
   output logic                  bst_req_o,
   output logic                  bst_wr_o,
   output logic [ADDR_W-1:0]     bst_addr_o,
   output logic [SGD_RGN_W-1:0]  bst_len_o,
   input  logic                  bst_ack_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  eot_o,
   output logic                  ovr_o
);
   localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(TBL_LIMIT);
   localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(SGD_DESC_STEP);

   generate
      if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
         $error("sgd_dma_engine: ADDR_W must lie in 16..32");
      end
      if (LEN_W < SGD_RGN_W || LEN_W > 32) begin : g_bad_len
         $error("sgd_dma_engine: LEN_W must lie in 17..32");
      end
      if (BURST_PAGE < 8 || BURST_PAGE > 65536 ||
          (BURST_PAGE & (BURST_PAGE - 1)) != 0) begin : g_bad_page
         $error("sgd_dma_engine: BURST_PAGE must be a power of two in 8..65536");
      end
      if (TBL_LIMIT == 0 || (TBL_LIMIT % SGD_DESC_STEP) != 0) begin : g_bad_limit
         $error("sgd_dma_engine: TBL_LIMIT must be a nonzero multiple of 8");
      end
   endgenerate

   sgd_state_e           state_q;
   logic [ADDR_W-1:0]    base_q;
   logic [ADDR_W-1:0]    ptr_q;
   logic [ADDR_W-1:0]    rgn_addr_q;
   logic [SGD_RGN_W-1:0] rem_q;
   logic                 last_q;
   logic [LEN_W-1:0]     need_q;
   logic                 wr_q;
   logic                 done_q;
   logic                 eot_q;
   logic                 ovr_q;

   logic [ADDR_W-1:0]    dec_addr;
   sgd_size_t            dec_size;
   logic [SGD_RGN_W-1:0] chunk;
   logic [ADDR_W-1:0]    walked;

   sgd_desc_decode #(
      .ADDR_W (ADDR_W)
   ) u_decode (
      .desc_i (dsc_data_i),
      .addr_o (dec_addr),
      .size_o (dec_size)
   );

   sgd_chunk_sel #(
      .LEN_W      (LEN_W),
      .ADDR_W     (ADDR_W),
      .BURST_PAGE (BURST_PAGE),
      .SPLIT_EN   (SPLIT_EN)
   ) u_chunk (
      .need_i  (need_q),
      .rem_i   (rem_q),
      .addr_i  (rgn_addr_q),
      .chunk_o (chunk)
   );

   assign walked = ptr_q - base_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= SGD_IDLE;
         base_q     <= '0;
         ptr_q      <= '0;
         rgn_addr_q <= '0;
         rem_q      <= '0;
         last_q     <= 1'b0;
         need_q     <= '0;
         wr_q       <= 1'b0;
         done_q     <= 1'b0;
         eot_q      <= 1'b0;
         ovr_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         eot_q  <= 1'b0;
         ovr_q  <= 1'b0;
         if (base_we_i) begin
            base_q <= base_i;
         end
         case (state_q)
            SGD_IDLE: begin
               if (start_i) begin
                  ptr_q      <= base_q;
                  rgn_addr_q <= '0;
                  rem_q      <= '0;
                  last_q     <= 1'b0;
                  need_q     <= len_i;
                  wr_q       <= dir_i;
                  state_q    <= SGD_EVAL;
               end
            end
            SGD_EVAL: begin
               if (need_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= SGD_IDLE;
               end else if (rem_q != '0) begin
                  state_q <= SGD_MOVE;
               end else if (last_q) begin
                  eot_q   <= 1'b1;
                  state_q <= SGD_IDLE;
               end else if (walked >= LIMIT_A) begin
                  ovr_q   <= 1'b1;
                  state_q <= SGD_IDLE;
               end else begin
                  state_q <= SGD_FETCH;
               end
            end
            SGD_FETCH: begin
               if (dsc_ack_i) begin
                  rgn_addr_q <= dec_addr;
                  rem_q      <= dec_size.len;
                  last_q     <= dec_size.last;
                  ptr_q      <= ptr_q + STEP_A;
                  state_q    <= SGD_EVAL;
               end
            end
            SGD_MOVE: begin
               if (bst_ack_i) begin
                  rgn_addr_q <= rgn_addr_q + ADDR_W'(chunk);
                  rem_q      <= rem_q - chunk;
                  need_q     <= need_q - LEN_W'(chunk);
                  state_q    <= SGD_EVAL;
               end
            end
            default: state_q <= SGD_IDLE;
         endcase
      end
   end

   assign dsc_req_o  = (state_q == SGD_FETCH);
   assign dsc_addr_o = ptr_q;
   assign bst_req_o  = (state_q == SGD_MOVE);
   assign bst_wr_o   = wr_q;
   assign bst_addr_o = rgn_addr_q;
   assign bst_len_o  = chunk;
   assign busy_o     = (state_q != SGD_IDLE);
   assign done_o     = done_q;
   assign eot_o      = eot_q;
   assign ovr_o      = ovr_q;
endmodule

// File: rtl/sgd_dma_chk.sv
module sgd_dma_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BURST_PAGE = 4096,
   parameter int unsigned TBL_LIMIT  = 4096,
   parameter bit          SPLIT_EN   = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] base_i,
   input logic              dsc_req_i,
   input logic [ADDR_W-1:0] dsc_addr_i,
   input logic              dsc_ack_i,
   input logic              bst_req_i,
   input logic              bst_wr_i,
   input logic [ADDR_W-1:0] bst_addr_i,
   input logic [16:0]       bst_len_i,
   input logic              bst_ack_i,
   input logic              busy_i,
   input logic              done_i,
   input logic              eot_i,
   input logic              ovr_i
);
   localparam int unsigned BP_W = $clog2(BURST_PAGE);

   logic [ADDR_W-1:0] fetch_ofs;
   logic [17:0]       burst_end;

   assign fetch_ofs = dsc_addr_i - base_i;
   assign burst_end = 18'(bst_addr_i[BP_W-1:0]) + 18'(bst_len_i);

   // R12
   one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dsc_req_i && bst_req_i));

   // R12
   bst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bst_req_i && !bst_ack_i) |=> (bst_req_i && $stable(bst_addr_i) &&
                                     $stable(bst_len_i) && $stable(bst_wr_i)));

   // R12
   dsc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dsc_req_i && !dsc_ack_i) |=> (dsc_req_i && $stable(dsc_addr_i)));

   // R9
   no_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bst_req_i && SPLIT_EN) |-> (burst_end <= 18'(BURST_PAGE)));

   // R7
   burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bst_req_i |-> (bst_len_i != 17'd0));

   // R6
   fetch_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dsc_req_i |-> (fetch_ofs < ADDR_W'(TBL_LIMIT)));

   // R2
   fetch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dsc_req_i |-> (fetch_ofs[2:0] == 3'd0));

   // R11
   end_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({done_i, eot_i, ovr_i}));

   // R11
   end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i || eot_i || ovr_i) |-> !busy_i);
endmodule

bind sgd_dma_engine sgd_dma_chk #(
   .ADDR_W     (ADDR_W),
   .BURST_PAGE (BURST_PAGE),
   .TBL_LIMIT  (TBL_LIMIT),
   .SPLIT_EN   (SPLIT_EN)
) u_sgd_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .base_i     (base_q),
   .dsc_req_i  (dsc_req_o),
   .dsc_addr_i (dsc_addr_o),
   .dsc_ack_i  (dsc_ack_i),
   .bst_req_i  (bst_req_o),
   .bst_wr_i   (bst_wr_o),
   .bst_addr_i (bst_addr_o),
   .bst_len_i  (bst_len_o),
   .bst_ack_i  (bst_ack_i),
   .busy_i     (busy_o),
   .done_i     (done_o),
   .eot_i      (eot_o),
   .ovr_i      (ovr_o)
);

// File: tb/tb_sgd_dma_engine.sv
module tb_sgd_dma_engine;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned LEN_W  = 24;

   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic              base_we_i = 1'b0;
   logic [ADDR_W-1:0] base_i = '0;
   logic              start_i = 1'b0;
   logic              dir_i = 1'b0;
   logic [LEN_W-1:0]  len_i = '0;
   logic              dsc_req_o;
   logic [ADDR_W-1:0] dsc_addr_o;
   logic              dsc_ack_i = 1'b0;
   logic [63:0]       dsc_data_i = '0;
   logic              bst_req_o;
   logic              bst_wr_o;
   logic [ADDR_W-1:0] bst_addr_o;
   logic [16:0]       bst_len_o;
   logic              bst_ack_i = 1'b0;
   logic              busy_o;
   logic              done_o;
   logic              eot_o;
   logic              ovr_o;

   always #5 clk_i = ~clk_i;

   sgd_dma_engine dut (
      .clk_i, .rst_ni, .base_we_i, .base_i, .start_i, .dir_i, .len_i,
      .dsc_req_o, .dsc_addr_o, .dsc_ack_i, .dsc_data_i,
      .bst_req_o, .bst_wr_o, .bst_addr_o, .bst_len_o, .bst_ack_i,
      .busy_o, .done_o, .eot_o, .ovr_o
   );

   typedef struct packed {
      logic [31:0] a;
      logic [16:0] l;
      logic        w;
   } bst_t;

   bst_t        exp_q[$];
   logic [63:0] tbl [0:511];
   logic [31:0] cur_base = '0;
   string       cur_tag = "R1";
   int          n_chk = 0;
   int          n_bad = 0;
   int          fetch_n = 0;
   int          end_kind = 0;
   int          lat = 0;
   int          wait_d = 0;
   int          wait_b = 0;
   bit          finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // responders and monitor, all at the falling edge
   always @(negedge clk_i) begin
      if (dsc_ack_i) begin
         dsc_ack_i = 1'b0;
      end else if (dsc_req_o) begin
         if (wait_d >= lat) begin
            check(dsc_addr_o == cur_base + 32'(8 * fetch_n), "R2", "fetch address",
                  dsc_addr_o, cur_base + 32'(8 * fetch_n));
            dsc_data_i = ((dsc_addr_o - cur_base) < 32'd4096) ?
                         tbl[(dsc_addr_o - cur_base) >> 3] : 64'd0;
            fetch_n++;
            dsc_ack_i = 1'b1;
            wait_d    = 0;
            lat       = (lat + 1) % 3;
         end else begin
            wait_d++;
         end
      end
      if (bst_ack_i) begin
         bst_ack_i = 1'b0;
      end else if (bst_req_o) begin
         if (wait_b >= lat) begin
            check(!dsc_req_o, "R12", "two requests at once", 1, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, cur_tag, "unexpected burst addr", bst_addr_o, 0);
            end else begin
               bst_t e;
               e = exp_q.pop_front();
               check({bst_addr_o, bst_len_o, bst_wr_o} == e, cur_tag, "burst addr/len/wr",
                     {bst_addr_o, bst_len_o, bst_wr_o}, e);
            end
            bst_ack_i = 1'b1;
            wait_b    = 0;
            lat       = (lat + 2) % 3;
         end else begin
            wait_b++;
         end
      end
      if (done_o) end_kind = 1;
      if (eot_o)  end_kind = 2;
      if (ovr_o)  end_kind = 3;
   end

   task automatic model(input int unsigned len, input bit dir,
                        output int kind, output int nf);
      longint      need;
      int unsigned rem;
      int unsigned c;
      int unsigned room;
      bit          last;
      int unsigned ptr;
      logic [31:0] a;
      logic [63:0] d;
      need = len; rem = 0; last = 0; ptr = 0; a = '0;
      kind = 1; nf = 0;
      while (need > 0) begin
         if (rem == 0) begin
            if (last) begin kind = 2; break; end
            if (ptr >= 4096) begin kind = 3; break; end
            d    = tbl[ptr / 8];
            ptr += 8;
            nf++;
            a    = d[31:0];
            rem  = int'(d[47:32] & 16'hFFFE);
            if (rem == 0) rem = 65536;
            last = d[63];
         end else begin
            c = int'(need);
            if (rem < c) c = rem;
            room = 4096 - (a % 4096);
            if (room < c) c = room;
            exp_q.push_back(bst_t'{a: a, l: 17'(c), w: dir});
            a    += c;
            rem  -= c;
            need -= c;
         end
      end
   endtask

   task automatic load_base(input logic [31:0] b);
      @(negedge clk_i);
      base_we_i = 1'b1;
      base_i    = b;
      @(negedge clk_i);
      base_we_i = 1'b0;
      cur_base  = b;
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < 512; i++) tbl[i] = '0;
   endtask

   task automatic run(input int unsigned len, input bit dir, input string tag);
      int kind;
      int nf;
      cur_tag = tag;
      exp_q.delete();
      model(len, dir, kind, nf);
      end_kind = 0;
      fetch_n  = 0;
      @(negedge clk_i);
      start_i = 1'b1;
      len_i   = LEN_W'(len);
      dir_i   = dir;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int k = 0; k < 40000 && end_kind == 0; k++) @(negedge clk_i);
      check(end_kind == kind, tag, "ending kind (1 done 2 eot 3 ovr)", end_kind, kind);
      check(exp_q.size() == 0, tag, "bursts still expected", exp_q.size(), 0);
      check(fetch_n == nf, tag, "descriptor fetch count", fetch_n, nf);
      check(!busy_o, tag, "busy after ending", busy_o, 0);
      repeat (2) @(negedge clk_i);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      clear_tbl();
      repeat (3) @(negedge clk_i);
      check({busy_o, dsc_req_o, bst_req_o, done_o, eot_o, ovr_o} == 6'd0, "R1",
            "outputs in reset", {busy_o, dsc_req_o, bst_req_o, done_o, eot_o, ovr_o}, 0);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);
      check({busy_o, dsc_req_o, bst_req_o, done_o, eot_o, ovr_o} == 6'd0, "R1",
            "outputs after reset", {busy_o, dsc_req_o, bst_req_o, done_o, eot_o, ovr_o}, 0);

      // R1 R2 R11: base never loaded, single last descriptor
      tbl[0] = {32'h8000_0200, 32'h1000_0000};
      run(32'h200, 1'b0, "R1 R2 R11");

      // R3 R4 R9 R10: odd size, 4 KiB split, zero means 64 KiB, write direction
      clear_tbl();
      load_base(32'h0000_2000);
      tbl[0] = {32'h0000_0101, 32'h0000_0FF0};
      tbl[1] = {32'h8000_0000, 32'h0000_5000};
      run(32'h10100, 1'b1, "R3 R4 R9 R10");

      // R5: table ends with bytes still owed
      clear_tbl();
      load_base(32'h0000_4000);
      tbl[0] = {32'h0000_0040, 32'h0010_0000};
      tbl[1] = {32'h8000_0020, 32'h0020_0000};
      run(32'h100, 1'b0, "R5");

      // R6: 512 small unflagged descriptors, fail-safe window reached
      clear_tbl();
      load_base(32'h0000_8000);
      for (int i = 0; i < 512; i++) tbl[i] = {32'h0000_0002, 32'h0003_0000 + 32'(i * 16)};
      run(32'h2000, 1'b0, "R6");

      // R7: count ends mid-region, later descriptor untouched
      clear_tbl();
      load_base(32'h0000_7000);
      tbl[0] = {32'h0000_0080, 32'h0040_0000};
      tbl[1] = {32'h0000_0100, 32'h0050_0000};
      tbl[2] = {32'h8000_0100, 32'h0060_0000};
      run(32'hC0, 1'b1, "R7");

      // R8: restart after a partly used region refetches from the base
      clear_tbl();
      load_base(32'h0000_6000);
      tbl[0] = {32'h8000_0100, 32'h0030_0000};
      run(32'h30, 1'b0, "R8 R7");
      run(32'h41, 1'b0, "R8");

      // R11: zero count completes with no fetch
      run(32'h0, 1'b0, "R11");

      summary();
   end
endmodule